// File: doc/BRIEF.md
# Test Access Port State Controller

This block is the sixteen-state sequencer at the heart of a boundary-scan test port. It advances on every rising edge of the test clock, and the serial mode-select input chooses between two successors at each edge. An active-low asynchronous test reset forces it into its reset state at any time. Holding the mode-select input high for five edges in a row also brings it to the reset state, whatever state it started from.

The current state is visible as a fixed 4-bit code. Per-state strobes for capture, shift, pause and update are decoded from that code for both the data-register column and the instruction-register column. Surrounding scan logic uses these strobes to load, shift, hold and apply its registers. An output-enable is also decoded; it marks the cycles in which the serial test output is driven.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low, `state_code` is 4'hF (test-logic-reset) at once, without waiting for a clock edge, and it stays 4'hF whatever `tms` does; after release, the controller starts from 4'hF.
- R2: Each state has a fixed 4-bit code. Data column: exit2 0, exit1 1, shift 2, pause 3, update 5, capture 6, select 7. Instruction column: select 4, exit2 8, exit1 9, shift A, pause B, update D, capture E. Others: run-test/idle C, test-logic-reset F.
- R3: Capture-DR goes to exit1 (1) when `tms` is high and to shift (2) when it is low. Shift-DR (2) holds while `tms` is low and goes to exit1 (1) when it is high.
- R4: From exit1-DR (1), `tms` low leads to pause (3) and `tms` high leads to update (5).
- R5: Pause-DR (3) holds while `tms` is low and goes to exit2 (0) when it is high.
- R6: From exit2-DR (0), `tms` high leads to update (5) and `tms` low returns to shift (2).
- R7: From update-DR (5) or update-IR (D), `tms` high leads to select-DR (7) and `tms` low leads to run-test/idle (C).
- R8: The instruction column (E, A, 9, B, 8, D, entered from select-IR 4) follows the same transitions as the data column.
- R9: After five consecutive rising edges with `tms` high, `state_code` is F, from any starting state.
- R10: Test-logic-reset goes to C on `tms` low and holds on high. Run-test/idle holds on low and goes to 7 on high. Select-DR goes to 6 on low and to 4 on high. Select-IR goes to E on low and to F on high.
- R11: Each capture, shift, pause and update strobe of each column is high exactly when `state_code` equals that state's code.
- R12: `tdo_en` is high only in shift-DR (2) and shift-IR (A).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; the state advances on its rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge of tck |
| state_code | output | 4 | Current state code |
| dr_capture | output | 1 | Data column capture strobe |
| dr_shift | output | 1 | Data column shift strobe |
| dr_pause | output | 1 | Data column pause strobe |
| dr_update | output | 1 | Data column update strobe |
| ir_capture | output | 1 | Instruction column capture strobe |
| ir_shift | output | 1 | Instruction column shift strobe |
| ir_pause | output | 1 | Instruction column pause strobe |
| ir_update | output | 1 | Instruction column update strobe |
| tdo_en | output | 1 | Serial test output is driven |

## Verification
Two things can act on the state in the same clock period: the asynchronous test reset and an edge-driven transition chosen by `tms`. The bench parks the controller in shift-DR with `tms` low. It then pulls `trst_n` low in the middle of the period, so that an edge that would otherwise hold the shift state arrives while the reset is active. The state and strobes are judged before that edge and again after edges taken with `tms` both high and low. All of them must show only test-logic-reset, and stepping must resume from F once the reset is released.

// File: rtl/tap_pkg.sv
package tap_pkg;

    // Fixed state codes; the code is exported unchanged on the state port.
    typedef enum logic [3:0] {
        ST_EX2_DR   = 4'h0,
        ST_EX1_DR   = 4'h1,
        ST_SHIFT_DR = 4'h2,
        ST_PAUSE_DR = 4'h3,
        ST_SEL_IR   = 4'h4,
        ST_UPD_DR   = 4'h5,
        ST_CAP_DR   = 4'h6,
        ST_SEL_DR   = 4'h7,
        ST_EX2_IR   = 4'h8,
        ST_EX1_IR   = 4'h9,
        ST_SHIFT_IR = 4'hA,
        ST_PAUSE_IR = 4'hB,
        ST_IDLE     = 4'hC,
        ST_UPD_IR   = 4'hD,
        ST_CAP_IR   = 4'hE,
        ST_RESET    = 4'hF
    } tap_state_e;

    // Per-column register-path strobes.
    typedef struct packed {
        logic capture;
        logic shift;
        logic pause;
        logic update;
    } path_strobe_t;

    // Number of consecutive high mode-select edges that guarantee reset.
    localparam int unsigned RESET_RUN = 5;

    function automatic tap_state_e tap_next(input tap_state_e cur, input logic tms);
        tap_state_e nxt;
        case (cur)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
            ST_EX1_DR:   nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
            ST_EX1_IR:   nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tap_state_reg.sv
module tap_state_reg
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

    // ---------------- checks on the sequencing ----------------
    localparam int unsigned RUN_W = $clog2(RESET_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RESET_RUN);

    logic [RUN_W-1:0] high_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            high_run <= '0;
        end else if (tms) begin
            high_run <= (high_run == RUN_MAX) ? high_run : high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    a_r9_five_high_resets: assert property (@(posedge tck) disable iff (!trst_n)
        (high_run == RUN_MAX) |-> (state == ST_RESET));

    a_r3_shift_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SHIFT_DR && !tms) |=> (state == ST_SHIFT_DR));

    a_r4_exit1_to_update: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EX1_DR && tms) |=> (state == ST_UPD_DR));

    a_r5_pause_to_exit2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_PAUSE_DR && tms) |=> (state == ST_EX2_DR));

    a_r6_exit2_back_to_shift: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EX2_DR && !tms) |=> (state == ST_SHIFT_DR));

    a_r7_update_to_idle: assert property (@(posedge tck) disable iff (!trst_n)
        ((state == ST_UPD_DR || state == ST_UPD_IR) && !tms) |=> (state == ST_IDLE));

endmodule

// File: rtl/tap_path_decode.sv
module tap_path_decode
    import tap_pkg::*;
#(
    parameter bit IR_PATH = 1'b0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_e   state,
    output path_strobe_t strb
);

    tap_state_e cap_code, sh_code, pa_code, up_code;

    generate
        if (IR_PATH) begin : g_ir
            assign cap_code = ST_CAP_IR;
            assign sh_code  = ST_SHIFT_IR;
            assign pa_code  = ST_PAUSE_IR;
            assign up_code  = ST_UPD_IR;
        end else begin : g_dr
            assign cap_code = ST_CAP_DR;
            assign sh_code  = ST_SHIFT_DR;
            assign pa_code  = ST_PAUSE_DR;
            assign up_code  = ST_UPD_DR;
        end
    endgenerate

    always_comb begin
        strb.capture = (state == cap_code);
        strb.shift   = (state == sh_code);
        strb.pause   = (state == pa_code);
        strb.update  = (state == up_code);
    end

    // A capture strobe is always followed by exit1 or shift, never by another capture.
    a_r11_capture_single_cycle: assert property (@(posedge tck) disable iff (!trst_n)
        strb.capture |=> !strb.capture && !strb.pause && !strb.update);

    a_r11_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(strb));

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output logic [3:0] state_code,
    output logic       dr_capture,
    output logic       dr_shift,
    output logic       dr_pause,
    output logic       dr_update,
    output logic       ir_capture,
    output logic       ir_shift,
    output logic       ir_pause,
    output logic       ir_update,
    output logic       tdo_en
);

    tap_state_e   cur_state;
    path_strobe_t dr_strb;
    path_strobe_t ir_strb;

    tap_state_reg u_state (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (cur_state)
    );

    tap_path_decode #(.IR_PATH(1'b0)) u_dr_dec (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (cur_state),
        .strb   (dr_strb)
    );

    tap_path_decode #(.IR_PATH(1'b1)) u_ir_dec (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (cur_state),
        .strb   (ir_strb)
    );

    assign state_code = cur_state;
    assign dr_capture = dr_strb.capture;
    assign dr_shift   = dr_strb.shift;
    assign dr_pause   = dr_strb.pause;
    assign dr_update  = dr_strb.update;
    assign ir_capture = ir_strb.capture;
    assign ir_shift   = ir_strb.shift;
    assign ir_pause   = ir_strb.pause;
    assign ir_update  = ir_strb.update;
    assign tdo_en     = dr_strb.shift | ir_strb.shift;

    // Staying in a shift state keeps the output driven on the next cycle.
    a_r12_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        ((dr_shift || ir_shift) && !tms) |=> tdo_en);

    a_r12_tdo_en_off_in_pause: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_pause || ir_pause) |-> !tdo_en);

    a_r8_ir_capture_from_select: assert property (@(posedge tck) disable iff (!trst_n)
        (state_code == 4'h4 && !tms) |=> ir_capture);

endmodule

// File: tb/tb_tap_ctrl.sv
`timescale 1ns/1ps
module tb_tap_ctrl;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] state_code;
    logic       dr_capture, dr_shift, dr_pause, dr_update;
    logic       ir_capture, ir_shift, ir_pause, ir_update;
    logic       tdo_en;

    int checks = 0;
    int errors = 0;
    int exp_state = 15;
    bit done = 1'b0;

    always #5 tck = ~tck;

    tap_ctrl dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_code(state_code),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_pause(dr_pause), .dr_update(dr_update),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_pause(ir_pause), .ir_update(ir_update),
        .tdo_en(tdo_en)
    );

    // Behavioural reference: states are tracked as column + step names.
    function automatic int model_next(int s, bit m);
        int r;
        if (s == 15) r = m ? 15 : 12;
        else if (s == 12) r = m ? 7 : 12;
        else if (s == 7) r = m ? 4 : 6;
        else if (s == 4) r = m ? 15 : 14;
        else if (s == 5 || s == 13) r = m ? 7 : 12;
        else begin
            // column-relative step: capture, shift, exit1, pause, exit2
            bit ir = (s >= 8);
            int cap = ir ? 14 : 6;
            int sh  = ir ? 10 : 2;
            int e1  = ir ? 9 : 1;
            int pa  = ir ? 11 : 3;
            int e2  = ir ? 8 : 0;
            int up  = ir ? 13 : 5;
            if (s == cap || s == sh) r = m ? e1 : sh;
            else if (s == e1) r = m ? up : pa;
            else if (s == pa) r = m ? e2 : pa;
            else r = m ? up : sh; // exit2
        end
        return r;
    endfunction

    task automatic check_outputs(input string tag);
        logic [12:0] act, exp;
        act = {state_code, dr_capture, dr_shift, dr_pause, dr_update,
               ir_capture, ir_shift, ir_pause, ir_update, tdo_en};
        exp = {4'(exp_state), exp_state == 6, exp_state == 2, exp_state == 3, exp_state == 5,
               exp_state == 14, exp_state == 10, exp_state == 11, exp_state == 13,
               (exp_state == 2 || exp_state == 10)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual %b expected %b (state actual %h expected %h)",
                     tag, act, exp, state_code, exp_state);
        end
    endtask

    // Drive tms away from the edge, take one edge, check at the falling edge.
    task automatic step(input bit m, input string tag);
        tms = m;
        @(posedge tck);
        exp_state = model_next(exp_state, m);
        @(negedge tck);
        check_outputs(tag);
    endtask

    task automatic walk(input string pattern, input string tag);
        for (int i = 0; i < pattern.len(); i++) begin
            step(pattern[i] == "1", tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state while trst_n low
        #12;
        exp_state = 15;
        check_outputs("R1 reset");
        @(negedge tck);
        trst_n = 1'b1;
        check_outputs("R1 release");

        // R10: reset hold, to idle, idle hold, select-DR
        walk("10", "R10 reset/idle");
        walk("0", "R10 idle hold");
        walk("1", "R10 idle to select");
        // R2 R3: capture-DR, shift hold, exit1
        walk("0", "R2 capture code");
        walk("00", "R3 shift hold");
        walk("1", "R3 shift to exit1");
        // R4 R5 R6: pause, exit2, back to shift, exit1, update
        walk("0", "R4 exit1 to pause");
        walk("00", "R5 pause hold");
        walk("1", "R5 pause to exit2");
        walk("0", "R6 exit2 to shift");
        walk("11", "R4 exit1 to update");
        walk("1", "R7 update to select");
        walk("0", "R10 select to capture");
        walk("11", "R3 capture to exit1 then update");
        walk("0", "R7 update to idle");
        // R2 R8: IR column
        walk("11", "R10 select IR");
        walk("0", "R8 capture IR");
        walk("001", "R8 shift IR");
        walk("001", "R8 pause/exit2 IR");
        walk("1", "R8 exit2 IR to update");
        walk("0", "R7 update IR to idle");
        walk("1101", "R8 capture IR to exit1");
        walk("0", "R8 exit1 IR to pause");
        walk("10", "R8 exit2 IR to shift");
        walk("11", "R8 update IR");
        walk("111", "R10 select IR to reset");

        // R9: five high edges from several states
        walk("0100", "R9 enter shift-DR");
        walk("11111", "R9 five high from shift");
        walk("0110100", "R9 enter pause-IR");
        walk("11111", "R9 five high from pause IR");

        // R1: async reset in mid-cycle while shifting
        walk("0100", "R1 enter shift-DR");
        tms = 1'b0;
        #2;
        trst_n = 1'b0;
        #1;
        exp_state = 15;
        check_outputs("R1 async mid-cycle");
        @(posedge tck);
        @(negedge tck);
        check_outputs("R1 held tms low");
        tms = 1'b1;
        @(posedge tck);
        @(negedge tck);
        check_outputs("R1 held tms high");
        trst_n = 1'b1;
        walk("0", "R1 resume from reset");

        // Random walk compared every clock (R2..R12)
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 1)), "R11 R12 random walk");
        end

        finish_run();
    end

endmodule